// File: doc/BRIEF.md
# Command-Pointer Two-Wire Register Slave

This block is the serial front end of a light-sensing macro. It listens on an open-drain two-wire bus (SMBus framing) and answers one of three 7-bit device addresses, chosen by a two-bit strap that encodes a pin tied low, left floating or tied high. It gives the bus master access to a 16-slot byte register space through a stored pointer. A written byte whose top bit is set is not data. It is a command that loads the pointer and carries an interrupt-clear request and two framing flags: word pairs and block transfers. Later reads and writes, including bare Receive Byte reads in later transactions, use that pointer.

The block keeps the writable configuration bytes itself and presents them as parallel outputs. It also pulses a write strobe with the address and data of every accepted write, and a one-cycle interrupt-clear strobe. The conversion core drives the two 16-bit channel results into the block. A read of a channel's low byte captures that channel's high byte in a shadow latch, so a later read of the high byte returns a value that matches the low byte, even if a new result has arrived in between. SCL and SDA are oversampled on the system clock, which must run at least eight times the SCL rate. The block never stretches the clock.

Top module: `smb_regslave`

## Requirements
- R1: The device address is 0x29 when addr_sel is 00, 0x39 when it is 01, and 0x49 when it is 10 or 11. A matching address byte is acknowledged (SDA pulled low in the ninth clock). A non-matching one gets no acknowledge, and the bytes that follow it, up to the next Start, have no effect.
- R2: Start (SDA falls while SCL is high) and Stop (SDA rises while SCL is high) are detected on the oversampled lines. After a Stop the slave releases SDA. sda_oe never changes while SCL stays high.
- R3: The first byte written after the address byte, if its bit 7 is 1, is a command. Bits 3:0 become the pointer, and a later Receive Byte returns the register the pointer selects.
- R4: Command bit 6 set produces exactly one clock cycle of int_clr. It is not stored, so a later command with bit 6 clear produces no pulse.
- R5: Command bit 5 (word mode) makes the pointer step by one after each data byte. A Write Word fills a low/high pair, and a Read Word returns low then high. Each new Start returns the pointer to the address held in the command.
- R6: Command bit 4 (block mode) steps the pointer after each byte. In a write, the first byte after the command is a byte count and is discarded. In a read, the first byte returned is a count slot of 00h, followed by consecutive registers.
- R7: After reset: ctrl_o = 00h, timing_o = 02h, both thresholds = 0000h, intr_cfg_o = 00h, and sda_oe, int_clr and reg_wr_stb are 0.
- R8: Writable registers keep only their defined bits: address 0h keeps bits 1:0 (so 03h reads back 03h), 1h keeps bits 4,3,1,0, 2h–5h keep all bits, and 6h keeps bits 5:0. The other bits read 0. thr_low_o is {3h,2h} and thr_high_o is {5h,4h}.
- R9: Writes to addresses 7h–Fh are acknowledged and discarded. Address Ah reads the ID parameter (default 50h), and 7h, 8h, 9h and Bh read 00h.
- R10: Reading Ch (channel 0 low) or Eh (channel 1 low) captures that channel's current high byte. Reading Dh or Fh returns the captured byte, even if the channel input has changed since.
- R11: Every accepted write to 0h–6h gives one reg_wr_stb cycle, with reg_wr_addr and the masked reg_wr_data.
- R12: When the master NACKs a read byte, the slave ends the read, releases SDA, and answers the next Start normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| addr_sel | input | 2 | Address strap: 00 low, 01 floating, 1x high |
| ch0_data | input | 16 | Channel 0 conversion result |
| ch1_data | input | 16 | Channel 1 conversion result |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr_stb | output | 1 | One-cycle strobe per accepted register write |
| reg_wr_addr | output | 4 | Address of the accepted write |
| reg_wr_data | output | 8 | Masked data of the accepted write |
| int_clr | output | 1 | One-cycle interrupt-clear strobe |
| ctrl_o | output | 8 | Power control register (0h) |
| timing_o | output | 8 | Gain and integration register (1h) |
| thr_low_o | output | 16 | Lower threshold {3h,2h} |
| thr_high_o | output | 16 | Upper threshold {5h,4h} |
| intr_cfg_o | output | 8 | Interrupt control register (6h) |

## Verification
The assertions check four rules on every cycle. SDA drive never changes while SCL is high. A Stop always releases SDA. The interrupt-clear strobe is never wider than one cycle. No write strobe ever names an address above 6h. The pointer also moves only on a byte event or a Start. The bench scenarios are needed for the rest: address decoding for each strap value, the discarded count byte and the 00h count slot in block mode, the pointer returning to its base between transactions, and the shadow byte surviving a change on the channel input. Each of these depends on a complete bus transaction.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_WDATA,
    LK_ACK_OUT,
    LK_RDATA,
    LK_ACK_IN
  } lk_state_t;

  localparam int         CFG_REGS   = 7;
  localparam logic [7:0] TIMING_RST = 8'h02;

  // Strap decode: low, floating, high (11 treated as high).
  function automatic logic [6:0] dev_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'h29;
      2'b01:   return 7'h39;
      default: return 7'h49;
    endcase
  endfunction

  // Bits kept by each writable register; zero means not writable.
  function automatic logic [7:0] keep_mask(input logic [3:0] a);
    case (a)
      4'h0:                   return 8'h03;
      4'h1:                   return 8'h1B;
      4'h2, 4'h3, 4'h4, 4'h5: return 8'hFF;
      4'h6:                   return 8'h3F;
      default:                return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_bus_cond.sv
module smb_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic          scl_p, sda_p;

  // Idle bus level is high, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_i};
      sda_sync <= {sda_sync[LAST-1:0], sda_i};
      scl_p    <= scl_sync[LAST];
      sda_p    <= sda_sync[LAST];
    end
  end

  assign scl_hi   = scl_sync[LAST];
  assign sda_lvl  = sda_sync[LAST];
  assign scl_rise = scl_sync[LAST] & ~scl_p;
  assign scl_fall = ~scl_sync[LAST] & scl_p;
  assign start_c  = scl_sync[LAST] & scl_p & sda_p & ~sda_sync[LAST];
  assign stop_c   = scl_sync[LAST] & scl_p & ~sda_p & sda_sync[LAST];

endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_hi,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_c,
  input  logic       stop_c,
  input  logic [6:0] my_addr,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       rd_adv
);
  lk_state_t  st;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= LK_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_byte <= '0;
      rd_adv  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_adv <= 1'b0;
      if (start_c) begin
        st     <= LK_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_ADDR, LK_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == LK_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= LK_ACK_OUT;
                end else begin
                  st <= LK_IDLE;
                end
              end else begin
                wr_stb  <= 1'b1;
                wr_byte <= sh;
                sda_oe  <= 1'b1;
                st      <= LK_ACK_OUT;
              end
            end
          end
          LK_ACK_OUT: begin
            if (scl_fall) begin
              if (rw) begin
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                rd_adv <= 1'b1;
                bitcnt <= 4'd1;
                st     <= LK_RDATA;
              end else begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= LK_WDATA;
              end
            end
          end
          LK_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= LK_ACK_IN;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          LK_ACK_IN: begin
            if (scl_rise && sda_lvl) begin
              st <= LK_IDLE;
            end else if (scl_fall) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              rd_adv <= 1'b1;
              bitcnt <= 4'd1;
              st     <= LK_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_oe)); // R2

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe); // R2

endmodule

// File: rtl/smb_regmap.sv
module smb_regmap
  import smb_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h50,
  parameter int         CH_W     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            txn_start,
  input  logic            wr_stb,
  input  logic [7:0]      wr_byte,
  input  logic            rd_adv,
  input  logic [CH_W-1:0] ch0_data,
  input  logic [CH_W-1:0] ch1_data,
  output logic [7:0]      rd_byte,
  output logic            reg_wr_stb,
  output logic [3:0]      reg_wr_addr,
  output logic [7:0]      reg_wr_data,
  output logic            int_clr,
  output logic [7:0]      ctrl_o,
  output logic [7:0]      timing_o,
  output logic [15:0]     thr_low_o,
  output logic [15:0]     thr_high_o,
  output logic [7:0]      intr_cfg_o
);
  logic [7:0] cfg_q [CFG_REGS];
  logic [3:0] base_q, cur_q;
  logic       word_q, blk_q, skip_q, first_wr, first_rd;
  logic [7:0] shad0, shad1;
  logic [7:0] rd_raw, wmask;
  logic       step;

  assign step  = word_q | blk_q;
  assign wmask = keep_mask(cur_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_REGS; i++) cfg_q[i] <= (i == 1) ? TIMING_RST : 8'h00;
      base_q      <= '0;
      cur_q       <= '0;
      word_q      <= 1'b0;
      blk_q       <= 1'b0;
      skip_q      <= 1'b0;
      first_wr    <= 1'b0;
      first_rd    <= 1'b0;
      shad0       <= '0;
      shad1       <= '0;
      int_clr     <= 1'b0;
      reg_wr_stb  <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      int_clr    <= 1'b0;
      reg_wr_stb <= 1'b0;
      if (txn_start) begin
        cur_q    <= base_q;
        first_wr <= 1'b1;
        first_rd <= 1'b1;
        skip_q   <= 1'b0;
      end else if (wr_stb) begin
        first_wr <= 1'b0;
        if (first_wr && wr_byte[7]) begin
          base_q  <= wr_byte[3:0];
          cur_q   <= wr_byte[3:0];
          int_clr <= wr_byte[6];
          word_q  <= wr_byte[5];
          blk_q   <= wr_byte[4];
          skip_q  <= wr_byte[4];
        end else if (skip_q) begin
          skip_q <= 1'b0;
        end else begin
          if (wmask != 8'h00) begin
            cfg_q[cur_q[2:0]] <= wr_byte & wmask;
            reg_wr_stb        <= 1'b1;
            reg_wr_addr       <= cur_q;
            reg_wr_data       <= wr_byte & wmask;
          end
          if (step) cur_q <= cur_q + 4'd1;
        end
      end else if (rd_adv) begin
        first_rd <= 1'b0;
        if (!(blk_q && first_rd)) begin
          if (cur_q == 4'hC) shad0 <= ch0_data[CH_W-1 -: 8];
          if (cur_q == 4'hE) shad1 <= ch1_data[CH_W-1 -: 8];
          if (step) cur_q <= cur_q + 4'd1;
        end
      end
    end
  end

  always_comb begin
    case (cur_q)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: rd_raw = cfg_q[cur_q[2:0]];
      4'hA:    rd_raw = ID_VALUE;
      4'hC:    rd_raw = ch0_data[7:0];
      4'hD:    rd_raw = shad0;
      4'hE:    rd_raw = ch1_data[7:0];
      4'hF:    rd_raw = shad1;
      default: rd_raw = 8'h00;
    endcase
  end

  assign rd_byte    = (blk_q && first_rd) ? 8'h00 : rd_raw;
  assign ctrl_o     = cfg_q[0];
  assign timing_o   = cfg_q[1];
  assign thr_low_o  = {cfg_q[3], cfg_q[2]};
  assign thr_high_o = {cfg_q[5], cfg_q[4]};
  assign intr_cfg_o = cfg_q[6];

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    int_clr |=> !int_clr); // R4

  AST_WR_ONLY_CFG: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |-> (reg_wr_addr <= 4'h6)); // R9

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && !rd_adv && !txn_start) |=> $stable(cur_q)); // R5

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_VALUE    = 8'h50,
  parameter int         CH_W        = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [1:0]      addr_sel,
  input  logic [CH_W-1:0] ch0_data,
  input  logic [CH_W-1:0] ch1_data,
  output logic            sda_oe,
  output logic            reg_wr_stb,
  output logic [3:0]      reg_wr_addr,
  output logic [7:0]      reg_wr_data,
  output logic            int_clr,
  output logic [7:0]      ctrl_o,
  output logic [7:0]      timing_o,
  output logic [15:0]     thr_low_o,
  output logic [15:0]     thr_high_o,
  output logic [7:0]      intr_cfg_o
);
  logic       scl_hi, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic       wr_stb, rd_adv;
  logic [7:0] wr_byte, rd_byte;
  logic [6:0] my_addr;

  assign my_addr = dev_addr(addr_sel);

  smb_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  smb_link u_link (
    .clk(clk), .rst(rst), .scl_hi(scl_hi), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
    .stop_c(stop_c), .my_addr(my_addr), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_adv(rd_adv)
  );

  smb_regmap #(.ID_VALUE(ID_VALUE), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .txn_start(start_c), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_adv(rd_adv), .ch0_data(ch0_data),
    .ch1_data(ch1_data), .rd_byte(rd_byte), .reg_wr_stb(reg_wr_stb),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .int_clr(int_clr), .ctrl_o(ctrl_o), .timing_o(timing_o),
    .thr_low_o(thr_low_o), .thr_high_o(thr_high_o), .intr_cfg_o(intr_cfg_o)
  );

endmodule

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HB         = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'b00;
  logic [15:0] ch0 = '0, ch1 = '0;
  logic        sda_oe, reg_wr_stb, int_clr;
  logic [3:0]  reg_wr_addr;
  logic [7:0]  reg_wr_data, ctrl_o, timing_o, intr_cfg_o;
  logic [15:0] thr_low_o, thr_high_o;
  wire         sda_bus = sda_m & ~sda_oe;

  smb_regslave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel(addr_sel),
    .ch0_data(ch0), .ch1_data(ch1), .sda_oe(sda_oe), .reg_wr_stb(reg_wr_stb),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .int_clr(int_clr),
    .ctrl_o(ctrl_o), .timing_o(timing_o), .thr_low_o(thr_low_o),
    .thr_high_o(thr_high_o), .intr_cfg_o(intr_cfg_o)
  );

  int n_tests = 0, n_fail = 0;
  int wr_pulses = 0, clr_cycles = 0;
  logic [6:0] dev = 7'h29;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] mdl  [7];

  always @(posedge clk) begin
    if (reg_wr_stb) wr_pulses <= wr_pulses + 1;
    if (int_clr)    clr_cycles <= clr_cycles + 1;
  end

  function automatic logic [7:0] b_keep(input int a);
    case (a)
      0: return 8'h03;
      1: return 8'h1B;
      6: return 8'h3F;
      default: return (a >= 2 && a <= 5) ? 8'hFF : 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HB) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic bstop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    ack = ~sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; half(); scl_m = 1'b1; half(); b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = nack; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half();
    sda_m = 1'b1;
  endtask

  task automatic t_write(input logic [7:0] cmd, input int n, output logic ok);
    logic a;
    bstart();
    wbyte({dev, 1'b0}, a); ok = a;
    wbyte(cmd, a); ok &= a;
    for (int i = 0; i < n; i++) begin wbyte(wbuf[i], a); ok &= a; end
    bstop();
  endtask

  task automatic t_read(input logic [7:0] cmd, input int n, output logic ok);
    logic a;
    bstart();
    wbyte({dev, 1'b0}, a); ok = a;
    wbyte(cmd, a); ok &= a;
    bstart();
    wbyte({dev, 1'b1}, a); ok &= a;
    for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
    bstop();
  endtask

  task automatic t_send(input logic [7:0] cmd, output logic ok);
    t_write(cmd, 0, ok);
  endtask

  task automatic t_recv(output logic [7:0] b, output logic ok);
    bstart();
    wbyte({dev, 1'b1}, ok);
    rbyte(1'b1, b);
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] b;
    int p0;
    void'($urandom(32'h1F2E));
    for (int i = 0; i < 7; i++) mdl[i] = (i == 1) ? 8'h02 : 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7 reset state
    chk("R7 cfg", {ctrl_o, timing_o, intr_cfg_o}, 32'h000200);
    chk("R7 thr", {thr_low_o, thr_high_o}, 32'h0);
    chk("R7 strobes", {sda_oe, int_clr, reg_wr_stb}, 32'h0);

    // R8 / R11 control register
    p0 = wr_pulses;
    wbuf[0] = 8'h03; t_write(8'h80, 1, ok);
    chk("R8 ctrl out", ctrl_o, 8'h03);
    chk("R11 pulse count", wr_pulses - p0, 1);
    chk("R11 addr/data", {reg_wr_addr, reg_wr_data}, 12'h003);
    t_recv(b, ok);
    chk("R8 ctrl readback", {ok, b}, 9'h103);
    wbuf[0] = 8'hFF; t_write(8'h81, 1, ok); mdl[1] = 8'h1B;
    chk("R8 timing mask", timing_o, 8'h1B);

    // R3 pointer from command, Receive Byte
    t_send(8'h80, ok);
    t_recv(b, ok);
    chk("R3 recv ptr0", b, 8'h03);
    t_send(8'h81, ok);
    t_recv(b, ok);
    chk("R3 recv ptr1", b, 8'h1B);

    // R1 address straps
    addr_sel = 2'b01; dev = 7'h39;
    t_send(8'h80, ok);
    chk("R1 float ack", ok, 1);
    dev = 7'h29;
    wbuf[0] = 8'h00; t_write(8'h80, 1, ok);
    chk("R1 miss nack", ok, 0);
    chk("R1 miss ignored", ctrl_o, 8'h03);
    addr_sel = 2'b10; dev = 7'h49;
    t_send(8'h80, ok);
    chk("R1 high ack", ok, 1);
    addr_sel = 2'b11;
    t_recv(b, ok);
    chk("R1 11 as high", {ok, b}, 9'h103);
    addr_sel = 2'b00; dev = 7'h29;

    // R4 interrupt clear pulse
    p0 = clr_cycles;
    t_send(8'hC6, ok);
    chk("R4 one pulse", clr_cycles - p0, 1);
    t_send(8'h86, ok);
    chk("R4 not stored", clr_cycles - p0, 1);

    // R5 word mode
    wbuf[0] = 8'h34; wbuf[1] = 8'h12; t_write(8'hA2, 2, ok);
    mdl[2] = 8'h34; mdl[3] = 8'h12;
    chk("R5 word write", thr_low_o, 16'h1234);
    t_read(8'hA2, 2, ok);
    chk("R5 word read", {rbuf[1], rbuf[0]}, 16'h1234);
    t_recv(b, ok);
    chk("R5 ptr back to base", b, 8'h34);

    // R6 block mode
    wbuf[0] = 8'hFF; wbuf[1] = 8'h78; wbuf[2] = 8'h56; wbuf[3] = 8'hDA;
    t_write(8'h94, 4, ok);
    mdl[4] = 8'h78; mdl[5] = 8'h56; mdl[6] = 8'h1A;
    chk("R6 block write thr", thr_high_o, 16'h5678);
    chk("R6 block write intr", intr_cfg_o, 8'h1A);
    t_read(8'h92, 5, ok);
    chk("R6 count slot", rbuf[0], 8'h00);
    chk("R6 block data", {rbuf[1], rbuf[2], rbuf[3], rbuf[4]}, 32'h34127856);

    // R9 read-only and reserved
    ch0 = 16'h1234; ch1 = 16'h5566;
    p0 = wr_pulses;
    wbuf[0] = 8'h77; t_write(8'h8A, 1, ok);
    chk("R9 ro write acked", ok, 1);
    wbuf[0] = 8'h99; t_write(8'h8C, 1, ok);
    chk("R9 no strobe", wr_pulses - p0, 0);
    t_send(8'h8A, ok); t_recv(b, ok);
    chk("R9 id", b, 8'h50);
    t_send(8'h87, ok); t_recv(b, ok);
    chk("R9 reserved 7", b, 8'h00);
    t_send(8'h8B, ok); t_recv(b, ok);
    chk("R9 reserved B", b, 8'h00);

    // R10 shadow latch
    t_send(8'h8C, ok); t_recv(b, ok);
    chk("R10 ch0 low", b, 8'h34);
    ch0 = 16'hABCD;
    t_send(8'h8D, ok); t_recv(b, ok);
    chk("R10 ch0 shadow", b, 8'h12);
    t_read(8'hAE, 2, ok);
    chk("R10 ch1 word", {rbuf[1], rbuf[0]}, 16'h5566);

    // R12 NACK releases the line, next access works
    chk("R12 released", sda_oe, 0);
    t_send(8'h80, ok);
    chk("R12 next ack", ok, 1);

    // Random writes with model readback (R8, R5)
    for (int k = 0; k < 16; k++) begin
      int a;
      logic [7:0] d0, d1;
      a  = $urandom_range(0, 6);
      d0 = 8'($urandom);
      d1 = 8'($urandom);
      if (a <= 5 && $urandom_range(0, 1) == 1) begin
        wbuf[0] = d0; wbuf[1] = d1; t_write(8'hA0 | 8'(a), 2, ok);
        mdl[a] = d0 & b_keep(a); mdl[a+1] = d1 & b_keep(a + 1);
        t_read(8'hA0 | 8'(a), 2, ok);
        chk("R5 random word", {rbuf[1], rbuf[0]}, {mdl[a+1], mdl[a]});
      end else begin
        wbuf[0] = d0; t_write(8'h80 | 8'(a), 1, ok);
        mdl[a] = d0 & b_keep(a);
        t_read(8'h80 | 8'(a), 1, ok);
        chk("R8 random byte", rbuf[0], mdl[a]);
      end
    end
    chk("R8 outputs vs model", {thr_low_o, thr_high_o}, {mdl[3], mdl[2], mdl[5], mdl[4]});
    chk("R8 cfg vs model", {ctrl_o, timing_o, intr_cfg_o}, {mdl[0], mdl[1], mdl[6]});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule